// File: doc/BRIEF.md
# Configurable GPIO Bank with Sticky Wake Capture

This block is a bank of general-purpose pins. Each pin has its own small control register. That register sets whether the pin drives or listens, which level counts as active, whether input events are held until software acknowledges them, and whether a held event may wake the system. The block never models the pad itself. It drives a separate output value and output enable for each pin, and it receives the raw pad level back.

An input first passes through a two-stage synchronizer. It is then flipped, if required, so that "active" always reads as 1.

- In level mode the status bit simply shows that adjusted level.
- In sticky mode a change from inactive to active is caught and held until the host writes a 0 into the status position.
- A held event on a pin that also has wake enabled pulls the shared active-low wake output low.

One pin, chosen by a parameter, can be handed to an alternate serial-data input. While it is handed over, that pin neither drives nor captures, and its synchronized level is routed to a dedicated output.

Each pin runs a four-state capture machine:

- **OFF**: the pin is driving, or it is claimed by the alternate function.
- **LEVEL**: the status bit follows the input level.
- **ARMED**: the pin is sticky and waiting for an event.
- **LATCHED**: an event is being held.

The machine moves as follows:

- **to_off**: taken from any state when the pin stops being a GPIO input.
- **to_level**: taken from any state when the pin is an input with sticky clear.
- **arm**: taken from OFF or LEVEL into ARMED when the pin is an input with sticky set.
- **catch**: ARMED to LATCHED on an inactive-to-active change.
- **ack**: LATCHED to ARMED when the host clears the status bit in a cycle with no new event.

Top module: `gpio_wake_bank`

## Requirements
- R1: After reset every register field reads 0, no pad is driven (`pad_oe` all 0, `pad_out` all 0), and `pme_n` is 1.
- R2: With output enable (bit 1) set and the type bit (bit 2) clear, the pin drives push-pull: `pad_oe`=1 and `pad_out` equals the data bit (bit 0). The status bit reads 0.
- R3: With output enable and the type bit both set, the pin is open drain: `pad_oe` is the inverse of the data bit, and `pad_out` is 0.
- R4: With output enable clear and sticky (bit 3) clear, the status bit (bit 5) reads the polarity-adjusted input. The type bit set means active high and clear means active low. The value appears within four clocks of a pad change.
- R5: With output enable clear and sticky set, an inactive-to-active change of the adjusted input sets the status bit. The bit stays set after the input returns inactive.
- R6: A held status bit is cleared by a register write carrying 0 in bit 5. A write carrying 1 in bit 5 leaves it set.
- R7: `pme_n` is 0 exactly while some pin has wake (bit 4) set and a held event. It returns to 1 once those events are cleared.
- R8: Wake on a pin in level mode never asserts `pme_n`, even with an active input.
- R9: While `alt_sel` is 1, pin ALT_PIN has `pad_oe`=0, reads status 0 and cannot assert `pme_n`, and `alt_sdata` follows its synchronized pad level. While `alt_sel` is 0, `alt_sdata` is 0.
- R10: Turning on output enable while an event is held discards the event: status reads 0 and `pme_n` returns to 1.
- R11: Bits 0 to 4 of each register read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | AW | Pin register select |
| host_wdata | input | 6 | Write data: bit0 data, bit1 out enable, bit2 polarity/type, bit3 sticky, bit4 wake, bit5 status |
| host_rdata | output | 6 | Read data for `host_addr`, same layout |
| alt_sel | input | 1 | Hands pin ALT_PIN to the alternate serial-data input |
| pad_in | input | NPINS | Raw pad levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| alt_sdata | output | 1 | Synchronized level of the claimed pin |
| pme_n | output | 1 | Active-low wake event |

## Verification
The hardest case to reach is a held event that must survive every path except a proper acknowledge. The event has to be reached through a real inactive-to-active change seen after the synchronizer, with the pin already ARMED. It must then be shown to ignore a write of 1 in the status position and the input falling back, and to leave only on the ack or to_off transitions. The stimulus first parks the pad inactive, arms the pin, and waits out the synchronizer before raising the pad. It then issues a write of 1, a write of 0, and a switch to output mode, checking status and `pme_n` after each. The alternate-claim case is driven the same way, with a hidden edge while claimed, followed by release without a spurious catch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int DATA_W = 6;

    // Bit positions inside a pin register
    localparam int B_DOUT   = 0;
    localparam int B_OE     = 1;
    localparam int B_PT     = 2;
    localparam int B_STICKY = 3;
    localparam int B_WAKE   = 4;
    localparam int B_STAT   = 5;

    typedef struct packed {
        logic wake;
        logic sticky;
        logic pt;
        logic oe;
        logic dout;
    } pin_cfg_t;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_LEVEL   = 2'd1,
        ST_ARMED   = 2'd2,
        ST_LATCHED = 2'd3
    } pin_state_e;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int    STAGES  = 2,
    parameter logic  RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int AW    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_wr,
    input  logic [AW-1:0]           host_addr,
    input  logic [DATA_W-1:0]       host_wdata,
    output logic [DATA_W-1:0]       host_rdata,
    input  logic [NPINS-1:0]        status_i,
    output pin_cfg_t [NPINS-1:0]    cfg_o,
    output logic [NPINS-1:0]        clr_o
);

    pin_cfg_t [NPINS-1:0] cfg_q;

    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_reg
            logic hit;
            assign hit = host_wr && (int'(host_addr) == g);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg_q[g] <= '0;
                end else if (hit) begin
                    cfg_q[g].dout   <= host_wdata[B_DOUT];
                    cfg_q[g].oe     <= host_wdata[B_OE];
                    cfg_q[g].pt     <= host_wdata[B_PT];
                    cfg_q[g].sticky <= host_wdata[B_STICKY];
                    cfg_q[g].wake   <= host_wdata[B_WAKE];
                end
            end

            // A write with 0 in the status position acknowledges a held event
            assign clr_o[g] = hit && !host_wdata[B_STAT];
        end
    endgenerate

    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (int'(host_addr) == i) begin
                host_rdata[B_DOUT]   = cfg_q[i].dout;
                host_rdata[B_OE]     = cfg_q[i].oe;
                host_rdata[B_PT]     = cfg_q[i].pt;
                host_rdata[B_STICKY] = cfg_q[i].sticky;
                host_rdata[B_WAKE]   = cfg_q[i].wake;
                host_rdata[B_STAT]   = status_i[i];
            end
        end
    end

    assign cfg_o = cfg_q;

    // R11: configuration only changes on a write strobe
    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(cfg_q));

endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pad_i,
    input  logic dout_i,
    input  logic oe_i,
    input  logic pt_i,
    input  logic sticky_i,
    input  logic alt_claim_i,
    input  logic clr_i,
    output logic pad_out_o,
    output logic pad_oe_o,
    output logic status_o,
    output logic latched_o,
    output logic alt_o
);

    pin_state_e state_q, state_d;
    logic       sync_lvl;
    logic       adj;
    logic       adj_q;
    logic       edge_hit;
    logic       in_mode;

    gpio_sync2 #(.STAGES(2), .RST_VAL(1'b0)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_i),
        .q_o   (sync_lvl)
    );

    assign in_mode  = !oe_i && !alt_claim_i;
    assign adj      = pt_i ? sync_lvl : !sync_lvl;
    assign edge_hit = adj && !adj_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adj_q <= 1'b0;
        end else begin
            adj_q <= adj;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (in_mode) begin
                    state_d = sticky_i ? ST_ARMED : ST_LEVEL;
                end
            end
            ST_LEVEL: begin
                if (!in_mode) begin
                    state_d = ST_OFF;
                end else if (sticky_i) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (!in_mode) begin
                    state_d = ST_OFF;
                end else if (!sticky_i) begin
                    state_d = ST_LEVEL;
                end else if (edge_hit) begin
                    state_d = ST_LATCHED;
                end
            end
            ST_LATCHED: begin
                if (!in_mode) begin
                    state_d = ST_OFF;
                end else if (!sticky_i) begin
                    state_d = ST_LEVEL;
                end else if (clr_i && !edge_hit) begin
                    state_d = ST_ARMED;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        status_o  = 1'b0;
        latched_o = 1'b0;
        pad_oe_o  = 1'b0;
        pad_out_o = 1'b0;
        unique case (state_q)
            ST_OFF:     status_o = 1'b0;
            ST_LEVEL:   status_o = adj;
            ST_ARMED:   status_o = 1'b0;
            ST_LATCHED: begin
                status_o  = 1'b1;
                latched_o = 1'b1;
            end
            default:    status_o = 1'b0;
        endcase
        if (oe_i && !alt_claim_i) begin
            if (pt_i) begin
                pad_oe_o  = !dout_i;
                pad_out_o = 1'b0;
            end else begin
                pad_oe_o  = 1'b1;
                pad_out_o = dout_i;
            end
        end
    end

    assign alt_o = alt_claim_i && sync_lvl;

    // R5: an event seen while armed is held on the next cycle
    assert_edge_catch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && in_mode && sticky_i && edge_hit) |=> (state_q == ST_LATCHED));

    // R6: acknowledge with no new event returns to armed
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCHED && in_mode && sticky_i && clr_i && !edge_hit) |=> (state_q == ST_ARMED));

    // R6: without an acknowledge a held event stays held
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCHED && in_mode && sticky_i && !clr_i) |=> (state_q == ST_LATCHED));

    // R3: open-drain never drives a high level
    assert_od_low_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_i && pt_i && !alt_claim_i) |-> !pad_out_o);

    // R9: a claimed pin never drives and never holds an event
    assert_alt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alt_claim_i |-> (!pad_oe_o && !latched_o));

    // R10: leaving input mode drops the capture state
    assert_off_when_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_mode |=> (state_q == ST_OFF));

endmodule

// File: rtl/gpio_wake_bank.sv
module gpio_wake_bank
    import gpio_pkg::*;
#(
    parameter int NPINS   = 4,
    parameter int ALT_PIN = 1,
    localparam int AW     = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [AW-1:0]     host_addr,
    input  logic [5:0]        host_wdata,
    output logic [5:0]        host_rdata,
    input  logic              alt_sel,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              alt_sdata,
    output logic              pme_n
);

    pin_cfg_t [NPINS-1:0] cfg;
    logic [NPINS-1:0]     clr;
    logic [NPINS-1:0]     status;
    logic [NPINS-1:0]     latched;
    logic [NPINS-1:0]     alt_vec;
    logic [NPINS-1:0]     wake_vec;

    gpio_regfile #(.NPINS(NPINS), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .status_i   (status),
        .cfg_o      (cfg),
        .clr_o      (clr)
    );

    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_pin
            logic claim;
            if (g == ALT_PIN) begin : g_alt
                assign claim = alt_sel;
            end else begin : g_plain
                assign claim = 1'b0;
            end

            gpio_pin u_pin (
                .clk         (clk),
                .rst_n       (rst_n),
                .pad_i       (pad_in[g]),
                .dout_i      (cfg[g].dout),
                .oe_i        (cfg[g].oe),
                .pt_i        (cfg[g].pt),
                .sticky_i    (cfg[g].sticky),
                .alt_claim_i (claim),
                .clr_i       (clr[g]),
                .pad_out_o   (pad_out[g]),
                .pad_oe_o    (pad_oe[g]),
                .status_o    (status[g]),
                .latched_o   (latched[g]),
                .alt_o       (alt_vec[g])
            );

            assign wake_vec[g] = cfg[g].wake;

            // R2: a pad is only driven when its output enable is set
            assert_oe_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
                pad_oe[g] |-> cfg[g].oe);
        end
    endgenerate

    assign pme_n     = !(|(latched & wake_vec));
    assign alt_sdata = |alt_vec;

    // R7, R8: a wake event needs a wake-enabled pin in sticky input mode
    assert_pme_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pme_n |-> (|(wake_vec & status)));

    // R8: level-mode wake pins never pull the wake output
    assert_level_no_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (&(~(latched))) |-> pme_n);

endmodule

// File: tb/sim_gpio_wake_bank.sv
`timescale 1ns/1ps
module sim_gpio_wake_bank;

    localparam int NPINS = 4;
    localparam int ALTP  = 1;
    localparam int AW    = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_wr = 1'b0;
    logic [AW-1:0]    host_addr = '0;
    logic [5:0]       host_wdata = '0;
    logic [5:0]       host_rdata;
    logic             alt_sel = 1'b0;
    logic [NPINS-1:0] pad_in = '1;
    logic [NPINS-1:0] pad_out;
    logic [NPINS-1:0] pad_oe;
    logic             alt_sdata;
    logic             pme_n;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    gpio_wake_bank #(.NPINS(NPINS), .ALT_PIN(ALTP)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .alt_sel    (alt_sel),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .alt_sdata  (alt_sdata),
        .pme_n      (pme_n)
    );

    // Vector: {req[3:0], cfg[4:0] (wake,sticky,pt,oe,dout), pad, exp_oe, exp_out, exp_status}
    localparam logic [12:0] VEC [8] = '{
        {4'd2, 5'b00010, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 push-pull low
        {4'd2, 5'b00011, 1'b0, 1'b1, 1'b1, 1'b0},  // R2 push-pull high
        {4'd3, 5'b00110, 1'b1, 1'b1, 1'b0, 1'b0},  // R3 open drain pulls low
        {4'd3, 5'b00111, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 open drain released
        {4'd4, 5'b00100, 1'b1, 1'b0, 1'b0, 1'b1},  // R4 active high, pad 1
        {4'd4, 5'b00100, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 active high, pad 0
        {4'd4, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 active low, pad 0
        {4'd4, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b0}   // R4 active low, pad 1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [5:0] d);
        @(negedge clk);
        host_addr  = AW'(a);
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [5:0] d);
        host_addr = AW'(a);
        #1;
        d = host_rdata;
    endtask

    task automatic run_tests();
        logic [5:0] r;
        // Reset state, R1
        cyc(3);
        for (int i = 0; i < NPINS; i++) begin
            rd(i, r);
            chk("R1 cfg", 32'(r[4:0]), 32'h0);
        end
        chk("R1 pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 pad_out", 32'(pad_out), 32'h0);
        chk("R1 pme_n", 32'(pme_n), 32'h1);
        rst_n = 1'b1;
        cyc(2);

        // Table walk on pin 0
        for (int v = 0; v < 8; v++) begin
            wr(0, {1'b0, VEC[v][8:4]});
            pad_in[0] = VEC[v][3];
            cyc(4);
            rd(0, r);
            chk($sformatf("R%0d oe vec%0d", VEC[v][12:9], v), 32'(pad_oe[0]), 32'(VEC[v][2]));
            chk($sformatf("R%0d out vec%0d", VEC[v][12:9], v), 32'(pad_out[0]), 32'(VEC[v][1]));
            chk($sformatf("R%0d status vec%0d", VEC[v][12:9], v), 32'(r[5]), 32'(VEC[v][0]));
        end

        // R11 readback
        wr(3, 6'h3F);
        cyc(1);
        rd(3, r);
        chk("R11 readback", 32'(r), 32'h1F);
        wr(3, 6'h0A);
        rd(3, r);
        chk("R11 readback 2", 32'(r), 32'h0A);
        wr(3, 6'h00);

        // R5 sticky capture, pin 0 active high
        pad_in[0] = 1'b0;
        cyc(3);
        wr(0, 6'h0C);
        cyc(3);
        rd(0, r);
        chk("R5 armed idle", 32'(r[5]), 32'h0);
        pad_in[0] = 1'b1;
        cyc(4);
        rd(0, r);
        chk("R5 caught", 32'(r[5]), 32'h1);
        pad_in[0] = 1'b0;
        cyc(4);
        rd(0, r);
        chk("R5 held after input drops", 32'(r[5]), 32'h1);

        // R6 acknowledge
        wr(0, 6'h2C);
        cyc(1);
        rd(0, r);
        chk("R6 write 1 keeps", 32'(r[5]), 32'h1);
        wr(0, 6'h0C);
        cyc(1);
        rd(0, r);
        chk("R6 write 0 clears", 32'(r[5]), 32'h0);

        // R7 wake
        wr(0, 6'h1C);
        cyc(2);
        chk("R7 no event", 32'(pme_n), 32'h1);
        pad_in[0] = 1'b1;
        cyc(4);
        chk("R7 asserted", 32'(pme_n), 32'h0);
        wr(0, 6'h1C);
        cyc(1);
        chk("R7 released", 32'(pme_n), 32'h1);

        // R10 output mode drops held event
        pad_in[0] = 1'b0;
        cyc(4);
        pad_in[0] = 1'b1;
        cyc(4);
        chk("R10 pre latched", 32'(pme_n), 32'h0);
        wr(0, 6'h1E);
        cyc(1);
        rd(0, r);
        chk("R10 status", 32'(r[5]), 32'h0);
        chk("R10 pme_n", 32'(pme_n), 32'h1);
        chk("R10 open drain low", 32'(pad_oe[0]), 32'h1);

        // R8 wake in level mode
        wr(2, 6'h14);
        pad_in[2] = 1'b1;
        cyc(4);
        rd(2, r);
        chk("R8 level status", 32'(r[5]), 32'h1);
        chk("R8 pme_n", 32'(pme_n), 32'h1);

        // R9 alternate claim on pin 1
        chk("R9 alt idle", 32'(alt_sdata), 32'h0);
        alt_sel = 1'b1;
        wr(1, 6'h1A);
        cyc(1);
        chk("R9 no drive", 32'(pad_oe[1]), 32'h0);
        wr(1, 6'h1C);
        pad_in[1] = 1'b0;
        cyc(4);
        chk("R9 alt low", 32'(alt_sdata), 32'h0);
        pad_in[1] = 1'b1;
        cyc(4);
        rd(1, r);
        chk("R9 alt high", 32'(alt_sdata), 32'h1);
        chk("R9 status", 32'(r[5]), 32'h0);
        chk("R9 pme_n", 32'(pme_n), 32'h1);
        alt_sel = 1'b0;
        cyc(3);
        rd(1, r);
        chk("R9 release no catch", 32'(r[5]), 32'h0);
        chk("R9 alt off", 32'(alt_sdata), 32'h0);
        pad_in[1] = 1'b0;
        cyc(4);
        pad_in[1] = 1'b1;
        cyc(4);
        chk("R7 wake from pin 1", 32'(pme_n), 32'h0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule